// File: doc/BRIEF.md
# Coarsened-Index Edge List Reader

This block turns a stream of source vertex IDs into the stream of edges leaving each vertex. The edge array in memory is sorted by source ID, and every record holds a source ID, a destination ID and a weight. The on-chip index that points into the array is coarsened: it keeps one starting edge index per group of `GROUP` consecutive vertices. This saves storage, but it means the reader cannot jump straight to a vertex's first edge.

For each accepted vertex ID the block reads the group's entry from an external synchronous index memory. It then streams whole edge lines from a memory read port, keeping up to `PF_DEPTH` lines outstanding or buffered. While it walks the records it drops the ones that belong to earlier vertices of the same group. It emits the matching records, one per cycle at most, and stops at the first record whose source ID is above the requested vertex.

When a scan ends, lines that were prefetched but not used are thrown away, including responses still in flight. A new request is accepted only after the current scan is finished.

Top module: `cixr_edge_reader`

## Requirements
- R1: During reset and in the first cycle after it, `req_ready` is 1 and both `out_valid` and `mem_req_valid` are 0.
- R2: The index lookup happens in the cycle a request is accepted (`req_valid` and `req_ready` both 1):
  - `tbl_rd_en` is 1 in that cycle.
  - `tbl_rd_addr` equals the requested ID divided by `GROUP`, where `GROUP` is a power of two.
  - The block samples `tbl_rd_data` in the following cycle.
- R3: Line requests follow the index entry:
  - The first line request after a lookup carries the entry divided by `EPL`.
  - Each further request of the same scan carries the previous address plus one.
  - The first record examined is slot (entry mod `EPL`) of that line.
  - Record k of a line occupies bits [48k+47:48k]: source in bits 47:32, destination in 31:16, weight in 15:0 (all within the record).
- R4: Records whose source ID is below the requested ID are consumed without being emitted. Every emitted edge carries the requested ID as its source.
- R5: All records whose source equals the requested ID are emitted, in memory order, with destination and weight unchanged.
- R6: A scan ends at the first record whose source ID exceeds the requested ID. The end-of-list marker, a record with an all-ones source, also ends a scan. After the scan ends `req_ready` returns to 1. A vertex with no edges produces no output.
- R7: The number of line requests issued but not yet answered never exceeds `PF_DEPTH` (4).
- R8: While `out_valid` is 1 and `out_ready` is 0:
  - `out_valid` stays 1 and the edge fields stay unchanged in the next cycle.
  - No edge is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Vertex request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vid | input | VID_W | Requested source vertex ID |
| tbl_rd_en | output | 1 | Index memory read strobe |
| tbl_rd_addr | output | VID_W-log2(GROUP) | Index memory group address |
| tbl_rd_data | input | EID_W | Starting edge index of the group, one cycle after the strobe |
| mem_req_valid | output | 1 | Edge line read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | EID_W-log2(EPL) | Edge line address |
| mem_rsp_valid | input | 1 | In-order line response |
| mem_rsp_data | input | EPL*(2*VID_W+WGT_W) | Line of EPL edge records |
| out_valid | output | 1 | Edge output valid |
| out_ready | input | 1 | Consumer accepts the edge |
| out_src | output | VID_W | Edge source ID |
| out_dst | output | VID_W | Edge destination ID |
| out_wgt | output | WGT_W | Edge weight |

## Verification
The hardest situation to reach is a scan that ends while several prefetched lines are still in flight. In that case the next request's first lines arrive behind responses that must be discarded. Stimulus gets there through short random degrees, so a scan often ends after one or two records, while memory responses are delayed at random and the next request arrives at once. A second hard case is a stop that lands on a line boundary during output backpressure. Repeated long stall windows on `out_ready`, layered over random readiness, reach it.

// File: rtl/cixr_pkg.sv
// Shared types for the coarsened-index edge reader.
package cixr_pkg;
    // Scan controller states
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_LOOK = 2'd1,
        SC_SCAN = 2'd2
    } scan_st_t;
endpackage

// File: rtl/cixr_line_fifo.sv
// Line buffer: holds prefetched edge lines in arrival order.
// Assumes the producer never pushes into a full buffer (credit control upstream).
// A clear empties it in one cycle and overrides a push in the same cycle.
module cixr_line_fifo #(
    parameter int W     = 192,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic                       head_valid,
    output logic [W-1:0]               head_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign head_valid = (count != '0);
    assign head_data  = store[rd_ptr];

    // Write the incoming line into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    // Advance the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/cixr_prefetch.sv
// Prefetch engine: issues sequential line reads while credit remains.
// Credit counts lines in flight plus lines buffered. On flush, every response
// still in flight is marked for discard. Assumes in-order responses.
module cixr_prefetch #(
    parameter int AW    = 14,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [AW-1:0]              start_line,
    input  logic                       active,
    input  logic                       flush,
    input  logic [$clog2(DEPTH+1)-1:0] buf_cnt,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic [AW-1:0]              mem_req_addr,
    input  logic                       mem_rsp_valid,
    output logic                       push
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] next_line;
    logic [CW-1:0] inflight, discard, inflight_n;
    logic          req_fire;

    assign mem_req_valid = active && (({1'b0, inflight} + {1'b0, buf_cnt}) < (CW+1)'(DEPTH));
    assign mem_req_addr  = next_line;
    assign req_fire      = mem_req_valid && mem_req_ready;
    assign push          = mem_rsp_valid && (discard == '0) && !flush;
    assign inflight_n    = inflight + CW'(req_fire) - CW'(mem_rsp_valid);

    // Track the next line address, lines in flight and pending discards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_line <= '0;
            inflight  <= '0;
            discard   <= '0;
        end else begin
            if (start)         next_line <= start_line;
            else if (req_fire) next_line <= next_line + 1'b1;
            inflight <= inflight_n;
            if (flush)                                 discard <= inflight_n;
            else if (mem_rsp_valid && discard != '0)   discard <= discard - 1'b1;
        end
    end
endmodule

// File: rtl/cixr_scan.sv
// Scan controller: looks up the group entry, then walks the buffered records.
// Lower sources are skipped, matching ones are emitted, and the scan stops at
// the first higher source. Assumes the requested ID is never all ones, which
// is reserved for the end-of-list marker.
module cixr_scan
    import cixr_pkg::*;
#(
    parameter int VID_W = 16,
    parameter int WGT_W = 16,
    parameter int EID_W = 16,
    parameter int GROUP = 2,
    parameter int EPL   = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic [VID_W-1:0]                 req_vid,
    output logic                             tbl_rd_en,
    output logic [VID_W-$clog2(GROUP)-1:0]   tbl_rd_addr,
    input  logic [EID_W-1:0]                 tbl_rd_data,
    output logic                             start,
    output logic [EID_W-$clog2(EPL)-1:0]     start_line,
    output logic                             scanning,
    output logic                             flush,
    input  logic                             head_valid,
    input  logic [EPL*(2*VID_W+WGT_W)-1:0]   head_line,
    output logic                             pop,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic [VID_W-1:0]                 out_src,
    output logic [VID_W-1:0]                 out_dst,
    output logic [WGT_W-1:0]                 out_wgt
);
    localparam int GSH   = $clog2(GROUP);
    localparam int ESH   = $clog2(EPL);
    localparam int EW    = 2*VID_W + WGT_W;
    localparam int OFF_W = (ESH > 0) ? ESH : 1;

    scan_st_t          st;
    logic [VID_W-1:0]  vid_q;
    logic [OFF_W-1:0]  off;
    logic [EW-1:0]     slot [EPL];
    logic [EW-1:0]     cur;
    logic [VID_W-1:0]  cur_src;
    logic              match, skip, stop, advance, last_slot;

    // Split the head line into its record slots.
    for (genvar s = 0; s < EPL; s++) begin : g_slot
        assign slot[s] = head_line[s*EW +: EW];
    end

    assign cur      = slot[off];
    assign cur_src  = cur[EW-1 -: VID_W];
    assign out_src  = cur_src;
    assign out_dst  = cur[WGT_W +: VID_W];
    assign out_wgt  = cur[WGT_W-1:0];

    assign req_ready   = (st == SC_IDLE);
    assign tbl_rd_en   = req_valid && req_ready;
    assign tbl_rd_addr = req_vid[VID_W-1:GSH];
    assign start       = (st == SC_LOOK);
    assign start_line  = tbl_rd_data[EID_W-1:ESH];
    assign scanning    = (st == SC_SCAN);

    assign match     = scanning && head_valid && (cur_src == vid_q);
    assign skip      = scanning && head_valid && (cur_src <  vid_q);
    assign stop      = scanning && head_valid && (cur_src >  vid_q);
    assign out_valid = match;
    assign advance   = skip || (match && out_ready);
    assign last_slot = (off == OFF_W'(EPL-1));
    assign pop       = advance && last_slot;
    assign flush     = stop;

    // Sequence lookup and scan, and step the slot offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SC_IDLE;
            vid_q <= '0;
            off   <= '0;
        end else begin
            unique case (st)
                SC_IDLE: if (tbl_rd_en) begin
                    vid_q <= req_vid;
                    st    <= SC_LOOK;
                end
                SC_LOOK: begin
                    off <= OFF_W'(tbl_rd_data & EID_W'(EPL-1));
                    st  <= SC_SCAN;
                end
                SC_SCAN: begin
                    if (stop)         st  <= SC_IDLE;
                    else if (advance) off <= last_slot ? '0 : off + 1'b1;
                end
                default: st <= SC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cixr_edge_reader.sv
// Coarsened-index edge reader top. It ties together the scan controller, the
// prefetch engine and the line buffer. Assumes GROUP and EPL are powers of two
// and that memory answers line reads in order.
module cixr_edge_reader #(
    parameter int VID_W    = 16,
    parameter int WGT_W    = 16,
    parameter int EID_W    = 16,
    parameter int GROUP    = 2,
    parameter int EPL      = 4,
    parameter int PF_DEPTH = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [VID_W-1:0]                    req_vid,
    output logic                                tbl_rd_en,
    output logic [VID_W-$clog2(GROUP)-1:0]      tbl_rd_addr,
    input  logic [EID_W-1:0]                    tbl_rd_data,
    output logic                                mem_req_valid,
    input  logic                                mem_req_ready,
    output logic [EID_W-$clog2(EPL)-1:0]        mem_req_addr,
    input  logic                                mem_rsp_valid,
    input  logic [EPL*(2*VID_W+WGT_W)-1:0]      mem_rsp_data,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [VID_W-1:0]                    out_src,
    output logic [VID_W-1:0]                    out_dst,
    output logic [WGT_W-1:0]                    out_wgt
);
    localparam int LW  = EPL * (2*VID_W + WGT_W);
    localparam int LAW = EID_W - $clog2(EPL);
    localparam int CW  = $clog2(PF_DEPTH + 1);

    logic           start, scanning, flush, push, pop, head_valid;
    logic [LAW-1:0] start_line;
    logic [LW-1:0]  head_line;
    logic [CW-1:0]  buf_cnt;

    cixr_scan #(
        .VID_W(VID_W), .WGT_W(WGT_W), .EID_W(EID_W), .GROUP(GROUP), .EPL(EPL)
    ) i_scan (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vid(req_vid),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
        .start(start), .start_line(start_line), .scanning(scanning), .flush(flush),
        .head_valid(head_valid), .head_line(head_line), .pop(pop),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_src(out_src), .out_dst(out_dst), .out_wgt(out_wgt)
    );

    cixr_prefetch #(.AW(LAW), .DEPTH(PF_DEPTH)) i_pf (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_line(start_line), .active(scanning), .flush(flush),
        .buf_cnt(buf_cnt),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .push(push)
    );

    cixr_line_fifo #(.W(LW), .DEPTH(PF_DEPTH)) i_buf (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .push(push), .push_data(mem_rsp_data), .pop(pop),
        .head_valid(head_valid), .head_data(head_line), .count(buf_cnt)
    );
endmodule

// File: rtl/cixr_checker.sv
// Port-level properties of the edge reader. It is attached to every instance
// through the bind at the end of this file.
module cixr_checker #(
    parameter int VID_W    = 16,
    parameter int WGT_W    = 16,
    parameter int GROUP    = 2,
    parameter int PF_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_ready,
    input logic [VID_W-1:0]               req_vid,
    input logic                           tbl_rd_en,
    input logic [VID_W-$clog2(GROUP)-1:0] tbl_rd_addr,
    input logic                           mem_req_valid,
    input logic                           mem_req_ready,
    input logic                           mem_rsp_valid,
    input logic                           out_valid,
    input logic                           out_ready,
    input logic [VID_W-1:0]               out_src,
    input logic [VID_W-1:0]               out_dst,
    input logic [WGT_W-1:0]               out_wgt
);
    localparam int GSH = $clog2(GROUP);
    localparam int CW  = $clog2(PF_DEPTH + 1) + 1;

    logic [VID_W-1:0] vid_seen;
    logic [CW-1:0]    pending;

    // Remember the accepted ID and count line requests not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_seen <= '0;
            pending  <= '0;
        end else begin
            if (req_valid && req_ready) vid_seen <= req_vid;
            pending <= pending + CW'(mem_req_valid && mem_req_ready) - CW'(mem_rsp_valid);
        end
    end

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!out_valid && !mem_req_valid));

    p_tbl_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (tbl_rd_en && tbl_rd_addr == req_vid[VID_W-1:GSH]));

    p_src_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_src == vid_seen));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= CW'(PF_DEPTH));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_src)
                                       && $stable(out_dst) && $stable(out_wgt)));
endmodule

bind cixr_edge_reader cixr_checker #(
    .VID_W(VID_W), .WGT_W(WGT_W), .GROUP(GROUP), .PF_DEPTH(PF_DEPTH)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vid(req_vid), .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_dst(out_dst), .out_wgt(out_wgt)
);

// File: tb/test_cixr_edge_reader.sv
// Bench: random graph with a coarsened index, directed plus random requests,
// random memory latency and output backpressure.
module test_cixr_edge_reader;
    localparam int NV   = 48;
    localparam int NREQ = 70;
    localparam int NMEM = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_vid = '0;
    logic         tbl_rd_en;
    logic [14:0]  tbl_rd_addr;
    logic [15:0]  tbl_rd_data = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [13:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [191:0] mem_rsp_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [15:0]  out_src, out_dst, out_wgt;

    always #2 clk = ~clk;

    cixr_edge_reader i_cixr_edge_reader (.*);

    int          nchk = 0, nfail = 0;
    int          deg [NV];
    int          first_e [NV+1];
    logic [47:0] emem [NMEM];
    int          reqs [NREQ];
    logic [47:0] expq [4096];
    int          ew = 0, er = 0;
    int          mq_addr [4096];
    int          mq_t [4096];
    int          mq_wr = 0, mq_rd = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Starting edge index stored for a vertex's group (GROUP = 2).
    function automatic int grp_entry(input int v);
        return first_e[(v / 2) * 2];
    endfunction

    // Edge line as memory returns it; past the list end, end markers.
    function automatic logic [191:0] line_of(input int a);
        logic [191:0] l;
        for (int k = 0; k < 4; k++)
            l[k*48 +: 48] = (a*4 + k < NMEM) ? emem[a*4+k] : {16'hFFFF, 32'h0};
        return l;
    endfunction

    initial begin
        int e, cyc, ri, cur_vid, outs_cnt, prev_line, rsp_now;
        bit busy, first_req, tbl_pend, clr_req, prev_stall, done;
        logic [47:0] prev_data;
        int tbl_pend_addr;
        void'($urandom(32'd2024));

        // Build the sorted edge array and the per-vertex first-edge indices.
        for (int v = 0; v < NV; v++) deg[v] = $urandom % 5;
        deg[4] = 3; deg[5] = 2; deg[6] = 0; deg[7] = 0; deg[NV-1] = 3;
        e = 0;
        for (int v = 0; v < NV; v++) begin
            first_e[v] = e;
            for (int k = 0; k < deg[v]; k++) begin
                emem[e] = {16'(v), 16'($urandom % NV), 16'($urandom)};
                e++;
            end
        end
        first_e[NV] = e;
        for (int i = e; i < NMEM; i++) emem[i] = {16'hFFFF, 32'h0};

        reqs[0] = 5; reqs[1] = 4; reqs[2] = 6; reqs[3] = 7; reqs[4] = NV-1; reqs[5] = 0;
        for (int i = 6; i < NREQ; i++) reqs[i] = $urandom % NV;

        // R1: reset state, checked while reset is held and just after release.
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && out_valid == 1'b0 && mem_req_valid == 1'b0,
            "R1 idle after reset", {req_ready, out_valid, mem_req_valid}, 3'b100);

        cyc = 0; ri = 0; cur_vid = 0; outs_cnt = 0; prev_line = 0;
        busy = 0; first_req = 0; tbl_pend = 0; clr_req = 0; prev_stall = 0; done = 0;
        prev_data = '0; tbl_pend_addr = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            // Drive inputs for the coming edge.
            tbl_rd_data = tbl_pend ? 16'(first_e[tbl_pend_addr * 2]) : 16'h0;
            tbl_pend = 0;
            if (clr_req) begin req_valid = 1'b0; clr_req = 0; end
            rsp_now = 0;
            if (mq_rd < mq_wr && cyc - mq_t[mq_rd] >= 2 && ($urandom % 4) != 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = line_of(mq_addr[mq_rd]);
                mq_rd++;
                rsp_now = 1;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            mem_req_ready = ($urandom % 4) != 0;
            out_ready = ((cyc % 150) < 15) ? 1'b0 : (($urandom % 4) != 0);
            if (!req_valid && ri < NREQ && ($urandom % 2) == 0) begin
                req_valid = 1'b1;
                req_vid = 16'(reqs[ri]);
            end
            #1;
            // R6: a finished scan produced exactly the vertex's edges.
            if (busy && req_ready) begin
                chk(outs_cnt == deg[cur_vid], "R6 edge count at scan end", outs_cnt, deg[cur_vid]);
                busy = 0;
            end
            if (req_valid && req_ready) begin
                // R2: group index presented in the accept cycle.
                chk(tbl_rd_en && tbl_rd_addr == 15'(req_vid / 2), "R2 index address",
                    {tbl_rd_en, tbl_rd_addr}, {1'b1, 15'(req_vid / 2)});
                cur_vid = int'(req_vid);
                tbl_pend = 1; tbl_pend_addr = cur_vid / 2;
                for (int i = first_e[cur_vid]; i < first_e[cur_vid+1]; i++) begin
                    expq[ew] = emem[i];
                    ew++;
                end
                busy = 1; first_req = 1; outs_cnt = 0; clr_req = 1; ri++;
            end
            if (mem_req_valid && mem_req_ready) begin
                // R3: first line from the entry, then consecutive lines.
                if (first_req)
                    chk(int'(mem_req_addr) == grp_entry(cur_vid) / 4, "R3 first line",
                        mem_req_addr, grp_entry(cur_vid) / 4);
                else
                    chk(int'(mem_req_addr) == prev_line + 1, "R3 next line", mem_req_addr, prev_line + 1);
                // R7: outstanding requests stay within the prefetch depth.
                chk(mq_wr - (mq_rd - rsp_now) < 4, "R7 outstanding", mq_wr - (mq_rd - rsp_now), 3);
                first_req = 0;
                prev_line = int'(mem_req_addr);
                mq_addr[mq_wr] = int'(mem_req_addr);
                mq_t[mq_wr] = cyc;
                mq_wr++;
            end
            if (prev_stall)
                // R8: stalled edge held steady.
                chk(out_valid && {out_src, out_dst, out_wgt} == prev_data, "R8 stall hold",
                    {out_valid, out_src, out_dst, out_wgt}, {1'b1, prev_data});
            if (out_valid && out_ready) begin
                // R4 and R5: emitted edge equals the next expected record.
                if (er < ew)
                    chk({out_src, out_dst, out_wgt} == expq[er], "R4/R5 edge value",
                        {out_src, out_dst, out_wgt}, expq[er]);
                else
                    chk(1'b0, "R5 extra edge", {out_src, out_dst, out_wgt}, 0);
                er++;
                outs_cnt++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data = {out_src, out_dst, out_wgt};
            if (ri == NREQ && !req_valid && req_ready && !busy) done = 1;
            if (cyc > 150000) begin
                chk(1'b0, "watchdog", cyc, 150000);
                done = 1;
            end
        end
        chk(er == ew, "R5 all edges delivered", er, ew);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule